// File: doc/BRIEF.md
# Fractional-Step SPI Serial Clock Generator

This block derives the SPI serial clock, a launch strobe and a latch strobe from a fast reference clock. It adds a programmable step to a phase accumulator whose modulus is 2048. Each time the running sum reaches the modulus, the serial clock toggles. The two toggles alternate between a leading edge, which moves away from the idle level, and a trailing edge. The SCLK period is therefore about 4096/step reference cycles, and the half period is about 2048/step. Software derives the step from the reference rate and the target rate, so any ratio can be reached without an integer divider.

The strobes are single reference-clock pulses. They appear in the same cycle as the matching SCLK transition. A shift engine uses the launch strobe to drive its next output bit and the latch strobe to sample the input. Per-profile bits choose which SCLK direction each strobe follows, and a polarity bit sets the idle level. A run input starts and stops clocking. An optional gate stops the clock while no slave is selected. A loop-start pulse can restart the accumulator at the beginning of each transfer loop. A small input stage lets the serial data input bypass its resynchronising register for very fast rates.

Top module: `spi_clkgen`

## Requirements
- R1: While rst_n is low, sclk, launch_stb, latch_stb and the internal accumulator are all 0.
- R2: While clocking is active, each cycle adds the effective step to the accumulator. When the sum reaches 2048, sclk toggles on the next output and the accumulator keeps the sum minus 2048. A step of 1024 therefore toggles sclk every 2nd cycle.
- R3: A freq_word of 0 acts as a step of 1. An effective step above 2048 is limited to 2048, which toggles sclk every cycle.
- R4: When clk_dbl is 1, the step is doubled before the upper limit of R3 is applied.
- R5: When no edge is pending, sclk rests at the level of cpol, so cpol=1 gives a high idle. The first edge after idle always moves away from that level.
- R6: launch_stb pulses in exactly the cycles where sclk makes a transition. The transition must be a rise (sclk becomes 1) when launch_rise=1, or a fall when launch_rise=0.
- R7: latch_stb follows the same rule as R6, with the edge direction chosen by latch_rise.
- R8: With run low, the next output has sclk equal to cpol and no strobe, and the accumulator clears to 0.
- R9: With run high, gate_en=1 and ss_active=0, the next output has sclk equal to cpol and no strobe. The accumulator keeps its value.
- R10: While clocking is active, a loop_start pulse with acc_rst_en=1 sets the accumulator to 0 and produces no edge in that cycle. With acc_rst_en=0, loop_start has no effect.
- R11: With async_sel=1, miso_out equals miso_in in the same cycle. With async_sel=0, miso_out is miso_in delayed by one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables clocking |
| loop_start | input | 1 | Pulse at the start of a transfer loop |
| ss_active | input | 1 | A slave select is asserted |
| freq_word | input | 16 | Accumulator step |
| acc_rst_en | input | 1 | Restart the accumulator on loop_start |
| clk_dbl | input | 1 | Double the step |
| launch_rise | input | 1 | Launch on rising sclk (else falling) |
| latch_rise | input | 1 | Latch on rising sclk (else falling) |
| cpol | input | 1 | Idle level of sclk |
| gate_en | input | 1 | Stop sclk while no slave is selected |
| async_sel | input | 1 | Bypass the input resync register |
| miso_in | input | 1 | Serial data input |
| sclk | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle launch strobe |
| latch_stb | output | 1 | One-cycle latch strobe |
| miso_out | output | 1 | Serial data to the shift engine |

## Verification
The bench targets these corner cases:
- The step extremes: 0, 1, and values past the 2048 limit, with and without doubling. A design that mishandled them would stall, overflow the accumulator, or toggle at the wrong rate.
- Uneven steps such as 700, whose remainder carries from one edge to the next. Dropping the remainder would shift every later edge.
- Run drops, gating and loop restarts in the middle of a period. These catch a design that leaves sclk stranded away from the idle level, forgets the accumulator state, or fires a stray strobe.
- Every combination of cpol with the launch and latch direction bits, plus both settings of the input path. These expose a strobe on the wrong edge or a missing bypass.

// File: rtl/spi_clkgen_pkg.sv
package spi_clkgen_pkg;
  // Result of one reference-clock step of the edge logic.
  typedef struct packed {
    logic sclk;
    logic launch;
    logic latch;
  } sclk_out_t;
endpackage

// File: rtl/spi_step_sel.sv
// Effective accumulator step: zero promoted to one, optional doubling,
// saturation at the modulus.
module spi_step_sel #(
  parameter int unsigned FCW_W = 16,
  parameter int unsigned ACC_W = 12
) (
  input  logic [FCW_W-1:0] freq_word,
  input  logic             clk_dbl,
  output logic [ACC_W-1:0] step
);
  localparam logic [FCW_W:0] MOD_W = (FCW_W+1)'(1) << (ACC_W-1);

  logic [FCW_W-1:0] base;
  logic [FCW_W:0]   scaled;

  always_comb begin
    base   = (freq_word == '0) ? FCW_W'(1) : freq_word;
    scaled = clk_dbl ? {base, 1'b0} : {1'b0, base};
    if (scaled >= MOD_W) step = MOD_W[ACC_W-1:0];
    else                 step = scaled[ACC_W-1:0];
  end
endmodule

// File: rtl/spi_phase_acc.sv
// Modulo phase accumulator; fire marks a modulus crossing.
module spi_phase_acc #(
  parameter int unsigned ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             restart,
  input  logic [ACC_W-1:0] step,
  output logic             fire
);
  localparam logic [ACC_W-1:0] MOD = ACC_W'(1) << (ACC_W-1);

  logic [ACC_W-1:0] acc_q, acc_d, sum;

  always_comb begin
    sum   = acc_q + step;
    acc_d = acc_q;
    fire  = 1'b0;
    if (clr) begin
      acc_d = '0;
    end else if (en) begin
      if (restart) begin
        acc_d = '0;
      end else if (sum >= MOD) begin
        acc_d = sum - MOD;
        fire  = 1'b1;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/spi_edge_gen.sv
// Serial clock level and edge-aligned strobes.
module spi_edge_gen
  import spi_clkgen_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active,
  input  logic      fire,
  input  logic      cpol,
  input  logic      launch_rise,
  input  logic      latch_rise,
  output sclk_out_t out_q
);
  logic      ph_q, ph_d;
  sclk_out_t out_d;

  always_comb begin
    ph_d         = active ? (ph_q ^ fire) : 1'b0;
    out_d.sclk   = ph_d ^ cpol;
    out_d.launch = active & fire & (out_d.sclk == launch_rise);
    out_d.latch  = active & fire & (out_d.sclk == latch_rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      out_q <= '0;
    end else begin
      ph_q  <= ph_d;
      out_q <= out_d;
    end
  end
endmodule

// File: rtl/spi_miso_path.sv
// Input stage: resynchronised or direct.
module spi_miso_path (
  input  logic clk,
  input  logic rst_n,
  input  logic async_sel,
  input  logic miso_in,
  output logic miso_out
);
  logic miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miso_q <= 1'b0;
    else        miso_q <= miso_in;
  end

  assign miso_out = async_sel ? miso_in : miso_q;
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
  import spi_clkgen_pkg::*;
#(
  parameter int unsigned FCW_W = 16,
  parameter int unsigned ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             loop_start,
  input  logic             ss_active,
  input  logic [FCW_W-1:0] freq_word,
  input  logic             acc_rst_en,
  input  logic             clk_dbl,
  input  logic             launch_rise,
  input  logic             latch_rise,
  input  logic             cpol,
  input  logic             gate_en,
  input  logic             async_sel,
  input  logic             miso_in,
  output logic             sclk,
  output logic             launch_stb,
  output logic             latch_stb,
  output logic             miso_out
);
  logic [ACC_W-1:0] step;
  logic             active, fire;
  sclk_out_t        eo;

  assign active = run & (ss_active | ~gate_en);

  spi_step_sel #(.FCW_W(FCW_W), .ACC_W(ACC_W)) u_step (
    .freq_word(freq_word), .clk_dbl(clk_dbl), .step(step)
  );

  spi_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(~run), .en(active),
    .restart(loop_start & acc_rst_en), .step(step), .fire(fire)
  );

  spi_edge_gen u_edge (
    .clk(clk), .rst_n(rst_n), .active(active), .fire(fire), .cpol(cpol),
    .launch_rise(launch_rise), .latch_rise(latch_rise), .out_q(eo)
  );

  spi_miso_path u_miso (
    .clk(clk), .rst_n(rst_n), .async_sel(async_sel),
    .miso_in(miso_in), .miso_out(miso_out)
  );

  assign sclk       = eo.sclk;
  assign launch_stb = eo.launch;
  assign latch_stb  = eo.latch;
endmodule

// File: rtl/spi_clkgen_chk.sv
module spi_clkgen_chk #(
  parameter int unsigned FCW_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             loop_start,
  input logic             ss_active,
  input logic [FCW_W-1:0] freq_word,
  input logic             acc_rst_en,
  input logic             clk_dbl,
  input logic             launch_rise,
  input logic             latch_rise,
  input logic             cpol,
  input logic             gate_en,
  input logic             async_sel,
  input logic             miso_in,
  input logic             sclk,
  input logic             launch_stb,
  input logic             latch_stb,
  input logic             miso_out
);
  a_r8_run_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sclk == $past(cpol)) && !launch_stb && !latch_stb);

  a_r9_gate_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && gate_en && !ss_active) |=> (sclk == $past(cpol)) && !launch_stb && !latch_stb);

  a_r6_launch_dir: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |-> (sclk == $past(launch_rise)));

  a_r7_latch_dir: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> (sclk == $past(latch_rise)));

  a_r10_restart_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (ss_active || !gate_en) && loop_start && acc_rst_en)
      |=> !launch_stb && !latch_stb);
endmodule

bind spi_clkgen spi_clkgen_chk #(.FCW_W(FCW_W)) chk (.*);

// File: tb/tb_spi_clkgen.sv
module tb_spi_clkgen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run, loop_start, ss_active, acc_rst_en, clk_dbl;
  logic        launch_rise, latch_rise, cpol, gate_en, async_sel, miso_in;
  logic [15:0] freq_word;
  logic        sclk, launch_stb, latch_stb, miso_out;

  always #10 clk = ~clk;

  spi_clkgen dut (.*);

  int    n_chk = 0, n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // behavioural reference
  int acc, ph;
  bit e_sclk, e_launch, e_latch, e_mq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc = 0; ph = 0; e_sclk = 0; e_launch = 0; e_latch = 0; e_mq = 0;
    end else begin
      int s; bit act, fire;
      s = (freq_word == 0) ? 1 : int'(freq_word);
      if (clk_dbl) s = s * 2;
      if (s > 2048) s = 2048;
      act  = run && (ss_active || !gate_en);
      fire = 0;
      if (!run) acc = 0;
      else if (act) begin
        if (loop_start && acc_rst_en) acc = 0;
        else begin
          acc = acc + s;
          if (acc >= 2048) begin acc = acc - 2048; fire = 1; end
        end
      end
      ph       = act ? (ph ^ int'(fire)) : 0;
      e_sclk   = ph[0] ^ cpol;
      e_launch = fire && (e_sclk == launch_rise);
      e_latch  = fire && (e_sclk == latch_rise);
      e_mq     = miso_in;
    end
  end

  task automatic chk1(string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk1("sclk", sclk, e_sclk);
    chk1("launch_stb", launch_stb, e_launch);
    chk1("latch_stb", latch_stb, e_latch);
    chk1("miso_out", miso_out, async_sel ? miso_in : e_mq);
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #3;
      miso_in = 1'($urandom);
    end
  endtask

  task automatic pulse_loop();
    @(posedge clk); #3; loop_start = 1'b1;
    @(posedge clk); #3; loop_start = 1'b0;
  endtask

  initial begin
    rst_n = 0; run = 0; loop_start = 0; ss_active = 0; acc_rst_en = 0;
    clk_dbl = 0; launch_rise = 0; latch_rise = 1; cpol = 0; gate_en = 0;
    async_sel = 0; miso_in = 0; freq_word = 16'd1024;
    tag = "R1"; cycles(4);
    rst_n = 1;
    tag = "R2"; run = 1; cycles(200);
    freq_word = 16'd700; cycles(400);
    freq_word = 16'd1; tag = "R3"; cycles(4500);
    freq_word = 16'd0; cycles(4500);
    freq_word = 16'd60000; cycles(100);
    tag = "R4"; clk_dbl = 1; freq_word = 16'd1500; cycles(100);
    freq_word = 16'd300; cycles(300);
    freq_word = 16'd0; cycles(2200);
    clk_dbl = 0; freq_word = 16'd512;
    tag = "R5"; cpol = 1; cycles(100);
    tag = "R6"; launch_rise = 1; latch_rise = 0; cycles(100);
    tag = "R7"; cpol = 0; launch_rise = 1; latch_rise = 1; cycles(80);
    launch_rise = 0; latch_rise = 0; cycles(80);
    launch_rise = 0; latch_rise = 1;
    tag = "R8";
    for (int k = 0; k < 6; k++) begin
      freq_word = 16'(333 + k * 211); cycles(7 + k * 3); run = 0; cycles(3); run = 1;
    end
    cpol = 1; cycles(9); run = 0; cycles(5); run = 1; cycles(20); cpol = 0;
    tag = "R9"; gate_en = 1; freq_word = 16'd600;
    for (int k = 0; k < 8; k++) begin
      ss_active = 1; cycles(5 + k); ss_active = 0; cycles(4);
    end
    ss_active = 1; cycles(30);
    tag = "R10"; acc_rst_en = 1; freq_word = 16'd900;
    for (int k = 0; k < 6; k++) begin cycles(2 + k); pulse_loop(); end
    acc_rst_en = 0;
    for (int k = 0; k < 6; k++) begin cycles(2 + k); pulse_loop(); end
    tag = "R11"; async_sel = 1; cycles(60); async_sel = 0; cycles(60);
    for (int k = 0; k < 20; k++) begin async_sel = 1'($urandom); cycles(3); end
    cycles(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog %s: actual hung expected finish", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule